// File: doc/BRIEF.md
# Exception Priority and Entry Sequencer

This block sits beside a small processor core. It decides which pending exception the core takes, then drives the entry sequence that follows. Four sources compete: reset, trace, interrupt and trap. Reset is raised by a rising edge on the external reset input or by a watchdog overflow pulse, and it is taken at once, even if another entry is in progress. Trace and interrupt are only looked at on the cycle the core reports a completed instruction. A trap strobe may be taken in any cycle in which the block is idle.

For trace, interrupt and trap, the block requests three stack writes in a fixed order: program counter, then flags, then extended control. Each write waits for the stack to acknowledge it. The block then pulses the mask-update and trace-clear strobes for one cycle. On the next cycle it presents the vector address together with a PC-load strobe.

Reset entry skips the stack writes and goes straight to the PC load. Two conditions suppress a source at an instruction boundary:
- Trace is not taken after a return-from-exception instruction.
- Interrupts are not sampled after an instruction that modifies the flags or control registers, nor at the first boundary after a reset entry.

Top module: `exc_sequencer`

## Requirements
- R1: A rising edge on `reset_pin` or a high `wdt_ovf` in any cycle, idle or busy, gives `pc_load`=1 with `vec_addr`=0 in the next cycle, with no stack push. Any entry already in progress is abandoned.
- R2: When several sources qualify in the same cycle, only the highest is taken, in the order reset, trace, interrupt, trap.
- R3: Trace is taken at a boundary (`instr_done`=1) only when `t_bit`=1 and `int_mode`=2.
- R4: Trace is not taken at a boundary whose `instr_class` is 1 (return from exception).
- R5: `irq_req` is not sampled at a boundary whose `instr_class` is 2, 3, 4 or 5 (flag AND, flag OR, flag XOR, control-register load). Class 0 is an ordinary instruction.
- R6: `irq_req` is not sampled at the first boundary seen while idle after a reset entry has completed.
- R7: `trap_req` is taken in any idle cycle, whether or not `instr_done` is high.
- R8: A non-reset entry starts one cycle after acceptance. It issues `push_req` with `push_tag` 0 (PC), then 1 (flags), then 2 (extended control). Each tag is held until a cycle in which `push_ready`=1.
- R9: In the cycle after the third push is acknowledged, `mask_upd` and `t_clear` are high for one cycle. In the cycle after that, `pc_load` is high for one cycle.
- R10: During `pc_load`, `vec_addr` equals four times the vector index. The indices are: reset 0, trace 5, trap 8+`trap_num`, interrupt 16+`irq_src`.
- R11: `busy` is high from the cycle after acceptance through the `pc_load` cycle and low afterwards. While busy, only reset is evaluated, and trap, trace and interrupt requests have no effect. After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| reset_pin | input | 1 | External reset level; rising edge starts reset entry |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| t_bit | input | 1 | Trace enable bit from the flags |
| int_mode | input | 2 | Interrupt control mode |
| irq_req | input | 1 | Interrupt request level |
| irq_src | input | IRQ_W | Interrupt source number |
| trap_req | input | 1 | Trap instruction strobe |
| trap_num | input | 2 | Trap number |
| instr_done | input | 1 | Instruction-complete strobe (boundary) |
| instr_class | input | 3 | Class of the completed instruction |
| push_ready | input | 1 | Stack write acknowledge |
| push_req | output | 1 | Stack write request |
| push_tag | output | 2 | Which register to push: 0 PC, 1 flags, 2 extended |
| mask_upd | output | 1 | Interrupt mask update strobe |
| t_clear | output | 1 | Trace bit clear strobe |
| vec_addr | output | VA_W | Vector address, valid with pc_load |
| pc_load | output | 1 | Load PC from vector strobe |
| busy | output | 1 | Entry sequence in progress |

## Verification
Priority is tried with every source raised alone, and with overlapping sets, including all four in one cycle. This separates a correct ordering from one that merely accepts something. Each suppression rule is tried with the suppressing class both present and absent on otherwise equal stimulus. This shows that the rule gates only its own source: after a flag-modifying class the interrupt is dropped but a same-cycle trap still goes through, and after a return the trace is dropped but an interrupt is taken. Random runs vary the acknowledge delay and inject requests mid-sequence, which exposes tags that advance early and entries that start while busy. A watchdog pulse in the middle of a push wait checks the abort path.

// File: rtl/exc_pkg.sv
// Shared encodings for the exception sequencer: source kinds, sequence
// states, instruction classes, push tags and vector indices.
package exc_pkg;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_RESET = 3'd1,
        K_TRACE = 3'd2,
        K_IRQ   = 3'd3,
        K_TRAP  = 3'd4
    } exc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_MASK = 2'd2,
        ST_LOAD = 2'd3
    } seq_state_e;

    localparam logic [2:0] CLS_PLAIN     = 3'd0;
    localparam logic [2:0] CLS_RETURN    = 3'd1;
    localparam logic [2:0] CLS_FLAG_AND  = 3'd2;
    localparam logic [2:0] CLS_FLAG_OR   = 3'd3;
    localparam logic [2:0] CLS_FLAG_XOR  = 3'd4;
    localparam logic [2:0] CLS_CTRL_LOAD = 3'd5;

    localparam logic [1:0] TRACE_MODE = 2'd2;
    localparam int         PUSH_COUNT = 3;

    localparam int VIDX_RESET = 0;
    localparam int VIDX_TRACE = 5;
    localparam int VIDX_TRAP  = 8;
    localparam int VIDX_IRQ   = 16;

    // True for classes after which interrupts must not be sampled.
    function automatic logic blocks_irq(input logic [2:0] cls);
        return (cls == CLS_FLAG_AND) || (cls == CLS_FLAG_OR) ||
               (cls == CLS_FLAG_XOR) || (cls == CLS_CTRL_LOAD);
    endfunction

endpackage

// File: rtl/exc_event_detect.sv
// Qualifies raw requests into candidate events.
// Reset is raised by a rising edge on the reset input or by a watchdog pulse.
// Trace and interrupt are qualified only at instruction boundaries.
// Assumes reset_pin is already synchronous to clk.
module exc_event_detect
    import exc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reset_pin,
    input  logic       wdt_ovf,
    input  logic       instr_done,
    input  logic [2:0] instr_class,
    input  logic       t_bit,
    input  logic [1:0] int_mode,
    input  logic       irq_req,
    input  logic       busy,
    input  logic       reset_done,
    output logic       reset_evt,
    output logic       trace_evt,
    output logic       irq_evt
);
    logic pin_q;
    logic post_reset;

    // Remember the previous reset level. A reset value of 1 means no edge is seen at start.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= reset_pin;
    end

    // Mask interrupt sampling up to the first idle boundary after a reset entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                   post_reset <= 1'b0;
        else if (reset_done)          post_reset <= 1'b1;
        else if (instr_done && !busy) post_reset <= 1'b0;
    end

    assign reset_evt = (reset_pin && !pin_q) || wdt_ovf;
    assign trace_evt = instr_done && t_bit && (int_mode == TRACE_MODE) &&
                       (instr_class != CLS_RETURN);
    assign irq_evt   = instr_done && irq_req && !post_reset &&
                       !blocks_irq(instr_class);
endmodule

// File: rtl/exc_arbiter.sv
// Fixed-priority selection among qualified events.
// Reset wins at any time. Other sources are considered only while idle.
// A lower-priority strobe that loses in a cycle is dropped.
module exc_arbiter
    import exc_pkg::*;
(
    input  logic      busy,
    input  logic      reset_evt,
    input  logic      trace_evt,
    input  logic      irq_evt,
    input  logic      trap_req,
    output logic      accept,
    output exc_kind_e kind
);
    // Pick the single winning source for this cycle.
    always_comb begin
        kind = K_NONE;
        if (reset_evt)      kind = K_RESET;
        else if (!busy) begin
            if (trace_evt)    kind = K_TRACE;
            else if (irq_evt) kind = K_IRQ;
            else if (trap_req) kind = K_TRAP;
        end
        accept = (kind != K_NONE);
    end
endmodule

// File: rtl/exc_vector_gen.sv
// Maps the winning source to its vector index. The vector table is laid out
// by fixed bases plus the trap number or the interrupt source.
module exc_vector_gen
    import exc_pkg::*;
#(
    parameter int IRQ_W = 4,
    parameter int IDX_W = 5
) (
    input  exc_kind_e        kind,
    input  logic [1:0]       trap_num,
    input  logic [IRQ_W-1:0] irq_src,
    output logic [IDX_W-1:0] idx
);
    // Base index for the kind, plus its sub-number where one applies.
    always_comb begin
        unique case (kind)
            K_TRACE: idx = IDX_W'(VIDX_TRACE);
            K_TRAP:  idx = IDX_W'(VIDX_TRAP) + IDX_W'(trap_num);
            K_IRQ:   idx = IDX_W'(VIDX_IRQ) + IDX_W'(irq_src);
            default: idx = IDX_W'(VIDX_RESET);
        endcase
    end
endmodule

// File: rtl/exc_entry_fsm.sv
// Entry sequence: three acknowledged pushes, one cycle of mask and trace
// clear, then one cycle of PC load. Reset skips straight to PC load and
// preempts every other state. Only one sequence runs at a time.
module exc_entry_fsm
    import exc_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  exc_kind_e        kind,
    input  logic [IDX_W-1:0] idx_in,
    input  logic             push_ready,
    output logic             push_req,
    output logic [1:0]       push_tag,
    output logic             mask_upd,
    output logic             t_clear,
    output logic             pc_load,
    output logic [IDX_W-1:0] vec_idx,
    output logic             busy,
    output logic             reset_done
);
    localparam int CNT_W = $clog2(PUSH_COUNT);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             is_reset;

    // Advance the sequence. Reset acceptance overrides every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            vec_idx  <= '0;
            is_reset <= 1'b0;
        end else if (accept && kind == K_RESET) begin
            state    <= ST_LOAD;
            cnt      <= '0;
            vec_idx  <= idx_in;
            is_reset <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    state    <= ST_PUSH;
                    cnt      <= '0;
                    vec_idx  <= idx_in;
                    is_reset <= 1'b0;
                end
                ST_PUSH: if (push_ready) begin
                    if (cnt == CNT_W'(PUSH_COUNT - 1)) state <= ST_MASK;
                    else                                cnt   <= cnt + 1'b1;
                end
                ST_MASK: state <= ST_LOAD;
                ST_LOAD: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign push_req   = (state == ST_PUSH);
    assign push_tag   = push_req ? 2'(cnt) : 2'd0;
    assign mask_upd   = (state == ST_MASK);
    assign t_clear    = (state == ST_MASK);
    assign pc_load    = (state == ST_LOAD);
    assign busy       = (state != ST_IDLE);
    assign reset_done = pc_load && is_reset;
endmodule

// File: rtl/exc_sequencer.sv
// Top level: request qualification, priority, vector lookup and entry
// sequencing. The core is assumed to stall while busy is high and to
// re-issue any trap strobe that lost arbitration.
module exc_sequencer
    import exc_pkg::*;
#(
    parameter  int IRQ_W = 4,
    localparam int IDX_W = $clog2(VIDX_IRQ + (1 << IRQ_W)),
    localparam int VA_W  = IDX_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reset_pin,
    input  logic             wdt_ovf,
    input  logic             t_bit,
    input  logic [1:0]       int_mode,
    input  logic             irq_req,
    input  logic [IRQ_W-1:0] irq_src,
    input  logic             trap_req,
    input  logic [1:0]       trap_num,
    input  logic             instr_done,
    input  logic [2:0]       instr_class,
    input  logic             push_ready,
    output logic             push_req,
    output logic [1:0]       push_tag,
    output logic             mask_upd,
    output logic             t_clear,
    output logic [VA_W-1:0]  vec_addr,
    output logic             pc_load,
    output logic             busy
);
    logic             reset_evt, trace_evt, irq_evt;
    logic             accept, reset_done;
    exc_kind_e        kind;
    logic [IDX_W-1:0] idx_sel, vec_idx;

    exc_event_detect u_detect (
        .clk(clk), .rst_n(rst_n), .reset_pin(reset_pin), .wdt_ovf(wdt_ovf),
        .instr_done(instr_done), .instr_class(instr_class), .t_bit(t_bit),
        .int_mode(int_mode), .irq_req(irq_req), .busy(busy),
        .reset_done(reset_done), .reset_evt(reset_evt),
        .trace_evt(trace_evt), .irq_evt(irq_evt)
    );

    exc_arbiter u_arb (
        .busy(busy), .reset_evt(reset_evt), .trace_evt(trace_evt),
        .irq_evt(irq_evt), .trap_req(trap_req), .accept(accept), .kind(kind)
    );

    exc_vector_gen #(.IRQ_W(IRQ_W), .IDX_W(IDX_W)) u_vec (
        .kind(kind), .trap_num(trap_num), .irq_src(irq_src), .idx(idx_sel)
    );

    exc_entry_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .accept(accept), .kind(kind),
        .idx_in(idx_sel), .push_ready(push_ready), .push_req(push_req),
        .push_tag(push_tag), .mask_upd(mask_upd), .t_clear(t_clear),
        .pc_load(pc_load), .vec_idx(vec_idx), .busy(busy),
        .reset_done(reset_done)
    );

    // The vector is a word address, driven only while the PC loads.
    assign vec_addr = pc_load ? {vec_idx, 2'b00} : '0;
endmodule

// File: rtl/exc_sequencer_chk.sv
// Temporal checks on the sequencer's ports, bound to every instance.
module exc_sequencer_chk #(
    parameter int VA_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reset_pin,
    input logic            wdt_ovf,
    input logic            push_ready,
    input logic            push_req,
    input logic [1:0]      push_tag,
    input logic            mask_upd,
    input logic            t_clear,
    input logic [VA_W-1:0] vec_addr,
    input logic            pc_load,
    input logic            busy
);
    logic pin_q;

    // Track the reset input level to see its rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= reset_pin;
    end

    logic rst_event;
    assign rst_event = wdt_ovf || (reset_pin && !pin_q);

    assert_reset_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_event |=> pc_load && vec_addr == '0 && !push_req);

    assert_push_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && !push_ready && !rst_event |=> push_req && $stable(push_tag));

    assert_tag_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> push_tag <= 2'd2);

    assert_last_push_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && push_ready && push_tag == 2'd2 && !rst_event |=> mask_upd && t_clear);

    assert_mask_then_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_upd |=> pc_load);

    assert_load_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load && !rst_event |=> !busy);

    assert_outputs_need_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req || mask_upd || pc_load) |-> busy);
endmodule

bind exc_sequencer exc_sequencer_chk #(.VA_W(VA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reset_pin(reset_pin), .wdt_ovf(wdt_ovf),
    .push_ready(push_ready), .push_req(push_req), .push_tag(push_tag),
    .mask_upd(mask_upd), .t_clear(t_clear), .vec_addr(vec_addr),
    .pc_load(pc_load), .busy(busy)
);

// File: tb/sim_exc_sequencer.sv
// Self-checking bench: directed corner cases plus seeded random requests.
module sim_exc_sequencer;
    localparam int IRQ_W = 4;
    localparam int VA_W  = 7;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, reset_pin, wdt_ovf, t_bit, irq_req, trap_req, instr_done, push_ready;
    logic [1:0] int_mode, trap_num, push_tag;
    logic [IRQ_W-1:0] irq_src;
    logic [2:0] instr_class;
    logic push_req, mask_upd, t_clear, pc_load, busy;
    logic [VA_W-1:0] vec_addr;

    exc_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .reset_pin(reset_pin), .wdt_ovf(wdt_ovf),
        .t_bit(t_bit), .int_mode(int_mode), .irq_req(irq_req), .irq_src(irq_src),
        .trap_req(trap_req), .trap_num(trap_num), .instr_done(instr_done),
        .instr_class(instr_class), .push_ready(push_ready), .push_req(push_req),
        .push_tag(push_tag), .mask_upd(mask_upd), .t_clear(t_clear),
        .vec_addr(vec_addr), .pc_load(pc_load), .busy(busy)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  post_rst = 1'b0;
    bit  reported = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
    endtask

    // Expected source: 0 none, 1 reset, 2 trace, 3 interrupt, 4 trap.
    function automatic int exp_kind(bit rst, bit tb, logic [1:0] mode, bit irq,
                                    logic [2:0] cls, bit done, bit trap, bit post);
        if (rst) return 1;
        if (done && tb && mode == 2'd2 && cls != 3'd1) return 2;
        if (done && irq && !post && !(cls >= 3'd2 && cls <= 3'd5)) return 3;
        if (trap) return 4;
        return 0;
    endfunction

    function automatic int exp_vec(int k, logic [1:0] tn, logic [IRQ_W-1:0] src);
        case (k)
            2:       return 5 * 4;
            3:       return (16 + int'(src)) * 4;
            4:       return (8 + int'(tn)) * 4;
            default: return 0;
        endcase
    endfunction

    task automatic clear_inputs();
        wdt_ovf = 0; trap_req = 0; instr_done = 0; irq_req = 0; reset_pin = 0;
    endtask

    // Follow a non-reset entry from the cycle after acceptance.
    task automatic follow(input int v, input int maxwait, input bit noise);
        for (int tag = 0; tag < 3; tag++) begin
            int d = (maxwait > 0) ? int'($urandom % (maxwait + 1)) : 0;
            for (int w = 0; w <= d; w++) begin
                chk(push_req && busy && push_tag == 2'(tag), "R8 push tag",
                    push_req ? int'(push_tag) : -1, tag);
                push_ready = (w == d);
                if (noise) begin
                    trap_req = 1'($urandom); instr_done = 1'($urandom);
                    irq_req = 1'($urandom); instr_class = 3'($urandom % 6);
                end
                @(negedge clk);
            end
        end
        push_ready = 0;
        trap_req = 0; instr_done = 0; irq_req = 0;
        chk(mask_upd && t_clear && !pc_load && !push_req, "R9 mask/clear", mask_upd, 1);
        @(negedge clk);
        chk(pc_load && !mask_upd, "R9 pc_load", pc_load, 1);
        chk(int'(vec_addr) == v, "R10 vector", int'(vec_addr), v);
        @(negedge clk);
        chk(!busy && !pc_load, "R11 busy ends", busy, 0);
    endtask

    task automatic run_case(input bit use_pin, input bit use_wdt, input bit tb,
                            input logic [1:0] mode, input bit irq,
                            input logic [IRQ_W-1:0] src, input logic [2:0] cls,
                            input bit done, input bit trap, input logic [1:0] tn,
                            input int maxwait, input bit noise, input string req);
        int k = exp_kind(use_pin || use_wdt, tb, mode, irq, cls, done, trap, post_rst);
        int v = exp_vec(k, tn, src);
        @(negedge clk);
        reset_pin = use_pin; wdt_ovf = use_wdt; t_bit = tb; int_mode = mode;
        irq_req = irq; irq_src = src; instr_class = cls; instr_done = done;
        trap_req = trap; trap_num = tn;
        @(negedge clk);
        clear_inputs();
        if (done) post_rst = 1'b0;
        if (k == 1) post_rst = 1'b1;
        if (k == 0) begin
            chk(!busy && !push_req && !pc_load, {req, " no entry"}, busy, 0);
        end else if (k == 1) begin
            chk(pc_load && vec_addr == '0 && !push_req, {req, " reset entry"}, pc_load, 1);
            @(negedge clk);
            chk(!busy, {req, " R11 idle after reset"}, busy, 0);
        end else begin
            chk(busy, {req, " R11 busy"}, busy, 1);
            follow(v, maxwait, noise);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; push_ready = 0; t_bit = 0; int_mode = 0; irq_src = 0;
        instr_class = 0; trap_num = 0;
        clear_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !push_req && !pc_load && !mask_upd && vec_addr == '0,
            "R11 reset state", busy, 0);

        // R1 reset via pin, then R6: first boundary after reset skips irq.
        run_case(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 pin");
        run_case(0, 0, 0, 0, 1, 4'd3, 3'd0, 1, 0, 0, 0, 0, "R6");
        run_case(0, 0, 0, 0, 1, 4'd3, 3'd0, 1, 0, 0, 1, 0, "R5 plain class irq");
        // R5 flag and control-load classes block irq.
        for (int c = 2; c <= 5; c++)
            run_case(0, 0, 0, 0, 1, 4'd7, 3'(c), 1, 0, 0, 0, 0, "R5 blocked");
        run_case(0, 0, 0, 0, 1, 4'd7, 3'd4, 1, 1, 2'd1, 0, 0, "R7 trap past blocked irq");
        // R3 / R4 trace gating.
        run_case(0, 0, 1, 2'd2, 0, 0, 3'd0, 1, 0, 0, 2, 0, "R3 trace");
        run_case(0, 0, 1, 2'd0, 0, 0, 3'd0, 1, 0, 0, 0, 0, "R3 wrong mode");
        run_case(0, 0, 0, 2'd2, 0, 0, 3'd0, 1, 0, 0, 0, 0, "R3 t clear");
        run_case(0, 0, 1, 2'd2, 0, 0, 3'd1, 1, 0, 0, 0, 0, "R4 after return");
        run_case(0, 0, 1, 2'd2, 1, 4'd9, 3'd1, 1, 0, 0, 1, 0, "R4 irq after return");
        run_case(0, 0, 1, 2'd2, 0, 0, 3'd0, 0, 0, 0, 0, 0, "R3 no boundary");
        // R2 priority.
        run_case(0, 1, 1, 2'd2, 1, 4'd1, 3'd0, 1, 1, 2'd3, 0, 0, "R2 all four");
        run_case(0, 0, 1, 2'd2, 1, 4'd1, 3'd0, 1, 1, 2'd3, 1, 0, "R2 first boundary");
        run_case(0, 0, 1, 2'd2, 1, 4'd1, 3'd0, 1, 1, 2'd3, 1, 0, "R2 trace over rest");
        run_case(0, 0, 0, 2'd2, 1, 4'd15, 3'd0, 1, 1, 2'd3, 1, 0, "R2 irq over trap");
        // R7 trap without boundary, every number (R10).
        for (int n = 0; n < 4; n++)
            run_case(0, 0, 0, 0, 0, 0, 3'd0, 0, 1, 2'(n), 3, 0, "R7 R10 trap");

        // R1 abort: watchdog in the middle of a push wait.
        @(negedge clk);
        irq_req = 1; irq_src = 4'd2; instr_done = 1; instr_class = 0;
        @(negedge clk);
        clear_inputs(); post_rst = 1'b0;
        chk(push_req && push_tag == 2'd0, "R8 abort setup", push_req, 1);
        wdt_ovf = 1;
        @(negedge clk);
        wdt_ovf = 0; post_rst = 1'b1;
        chk(pc_load && vec_addr == '0 && !push_req, "R1 abort", int'(vec_addr), 0);
        @(negedge clk);
        chk(!busy, "R1 idle after abort", busy, 0);

        // Random mix with mid-sequence noise (R11).
        for (int i = 0; i < 400; i++) begin
            bit r = (($urandom % 16) == 0);
            run_case(r && 1'($urandom), r && 1'($urandom) == 0 ? 1'b0 : 1'b0,
                     1'($urandom), 2'($urandom), 1'($urandom), IRQ_W'($urandom),
                     3'($urandom % 6), 1'($urandom), 1'($urandom), 2'($urandom),
                     3, 1, "R2 R11 random");
        end

        report();
        $finish;
    end
endmodule